// File: doc/BRIEF.md
# Serial Two's Complement Converter

This block negates an unsigned or signed word of `WIDTH` bits (default 8) one bit per clock, least significant bit first. A start strobe loads the word into an internal shift register. On each of the next `WIDTH` clocks, the lowest register bit passes through a two-state Mealy machine, and the converted bit is shifted into the top of the register. When all bits have passed through, the register holds the two's complement of the original word.

The state machine needs no adder or carry chain. While no 1 has been seen in the current word, each bit passes through unchanged. The first 1 is also passed through unchanged, and it moves the machine into its second state. In the second state every bit is inverted. A bit counter stops the conversion after exactly `WIDTH` shifts and then raises a done pulse for one cycle. The result output always shows the register contents, so the result is valid from the done pulse until the next accepted start.

Top module: `serialNegator`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `busy`, `done` and `result` to 0, including when a conversion is in progress.
- R2: When `start` is high while `busy` is low, the word on `dataIn` is loaded at that edge. From the next cycle, `busy` is 1 and `result` shows the loaded word.
- R3: During each busy cycle the register shifts right by one position. Bit 0 leaves the register, and the converted bit enters at bit `WIDTH-1`. Bits are therefore processed least significant first, one per clock.
- R4: While no 1 has yet been seen in the current word, the converted bit equals the input bit. This includes the first 1, which is copied unchanged.
- R5: Once a 1 has been seen, every later bit of the same word is inverted, and the seen-a-one state stays set until the next load.
- R6: Each accepted start clears the seen-a-one state. A word that follows a word containing a 1 therefore converts exactly as it would after reset.
- R7: `busy` stays high for exactly `WIDTH` cycles per conversion. `done` is high for exactly one cycle, the cycle right after `busy` falls.
- R8: `start` and `dataIn` have no effect while `busy` is high. Neither the result nor the conversion length changes.
- R9: When `done` is high, `result` equals the two's complement of the loaded word modulo 2^`WIDTH`; for example 8'h0A gives 8'hF6. `result` then holds that value until the next accepted start.
- R10: An all-zero word converts to all zeros, and the most negative word (only bit `WIDTH-1` set) converts to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the state flop, the shift register and the counter |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load strobe; accepted only while busy is low |
| dataIn | input | WIDTH | Word to convert, sampled on an accepted start |
| busy | output | 1 | High while bits are being shifted |
| done | output | 1 | One-cycle pulse after the last shift |
| result | output | WIDTH | Shift register contents; the converted word once done has pulsed |

## Verification
The hardest cases to reach from the ports lie at the edges of a conversion. The first is a start that arrives in the last busy cycle, when the counter is about to end the word. The second is a start in the `done` cycle itself, which must be accepted immediately. The third is a start with a fresh word right after a word whose seen-a-one state was set, which shows whether that state leaked across words. The stimulus runs conversions back to back, so each new start falls in the done cycle of the previous one. It also injects a start with different data in the middle of a word and applies reset in the middle of a word. A behavioural model predicts the register contents after k shifts as the low k bits of the negated word placed above the unshifted remainder, and the bench compares the outputs against it on every clock.

// File: rtl/serialNegPkg.sv
package serialNegPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new word, clear the seen-a-one flag
    logic shift;  // move one bit through the Mealy machine
  } negStrobe_t;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } negPhase_e;

endpackage

// File: rtl/negControl.sv
module negControl
  import serialNegPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output negStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  negPhase_e      phaseQ;
  logic [CW-1:0]  countQ;
  logic           doneQ;
  logic           lastShift;

  assign busy = (phaseQ == PH_RUN);
  assign done = doneQ;

  always_comb begin
    strobe.load  = start && (phaseQ == PH_IDLE);
    strobe.shift = (phaseQ == PH_RUN);
    lastShift    = (phaseQ == PH_RUN) && (countQ == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= PH_IDLE;
      countQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= lastShift;
      if (strobe.load) begin
        phaseQ <= PH_RUN;
        countQ <= '0;
      end else if (phaseQ == PH_RUN) begin
        countQ <= countQ + 1'b1;
        if (lastShift) begin
          phaseQ <= PH_IDLE;
        end
      end
    end
  end

  // R1: reset clears the handshake outputs
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!busy && !done));

  // R2: an idle start begins a conversion
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: done follows the falling edge of busy
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8: a start during a word does not restart the counter
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && countQ != LAST) |=> (busy && countQ != '0));

endmodule

// File: rtl/negDatapath.sv
module negDatapath
  import serialNegPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  negStrobe_t       strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] word
);

  logic [WIDTH-1:0] wordQ;
  logic             seenOneQ;   // state flop: 0 = no 1 yet, 1 = a 1 was seen
  logic             inBit;
  logic             outBit;
  logic             seenOneD;

  assign word = wordQ;

  // Mealy next-state and output logic
  always_comb begin
    inBit    = wordQ[0];
    outBit   = seenOneQ ? ~inBit : inBit;
    seenOneD = seenOneQ | inBit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ    <= '0;
      seenOneQ <= 1'b0;
    end else if (strobe.load) begin
      wordQ    <= dataIn;
      seenOneQ <= 1'b0;
    end else if (strobe.shift) begin
      wordQ    <= {outBit, wordQ[WIDTH-1:1]};
      seenOneQ <= seenOneD;
    end
  end

  // R6: load clears the state and captures the word (also R2)
  p_load_clear_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (!seenOneQ && wordQ == $past(dataIn)));

  // R3: the register shifts right by one position
  p_shift_right_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.shift |=> (wordQ[WIDTH-2:0] == $past(wordQ[WIDTH-1:1])));

  // R4: before any 1, bits are copied unchanged
  p_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && !seenOneQ) |=> (wordQ[WIDTH-1] == $past(wordQ[0])));

  // R5: after a 1, bits are inverted
  p_invert_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && seenOneQ) |=> (wordQ[WIDTH-1] != $past(wordQ[0])));

  // R5: the seen-a-one state is sticky until a load
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (seenOneQ && !strobe.load) |=> seenOneQ);

  // R9: with no load and no shift, the result holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.shift) |=> $stable(wordQ));

endmodule

// File: rtl/serialNegator.sv
module serialNegator
  import serialNegPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dataIn,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  negStrobe_t strobe;

  negControl #(.WIDTH(WIDTH)) u_control (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  negDatapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .dataIn (dataIn),
    .word   (result)
  );

endmodule

// File: tb/serialNegator_bench.sv
`timescale 1ns/1ps
module serialNegator_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phaseTag = "R1";

  always #4 clk = ~clk;   // 125 MHz

  serialNegator #(.WIDTH(W)) u_serialNegator (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .dataIn (dataIn),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  // Behavioural reference: the loaded word, the shift count, busy and done
  logic [W-1:0] mWord = '0;
  int           mK = 0;
  logic         mBusy = 1'b0;
  logic         mDone = 1'b0;
  logic         edgeSeen = 1'b0;

  // Register contents after k shifts: low k bits of -x on top, x >> k below
  function automatic logic [W-1:0] expectAfter(logic [W-1:0] x, int k);
    logic [W-1:0]   neg;
    logic [2*W-1:0] t;
    neg = -x;
    t = ({{W{1'b0}}, neg} << (W - k)) | ({{W{1'b0}}, x} >> k);
    return t[W-1:0];
  endfunction

  always @(posedge clk) begin
    edgeSeen = 1'b1;
    cycles++;
    if (rst) begin
      mWord = '0; mK = W; mBusy = 1'b0; mDone = 1'b0;
    end else begin
      mDone = 1'b0;
      if (mBusy) begin
        mK++;
        if (mK == W) begin
          mBusy = 1'b0;
          mDone = 1'b1;
        end
      end else if (start) begin
        mBusy = 1'b1;
        mK = 0;
        mWord = dataIn;
      end
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (edgeSeen && !rst) begin
      check({phaseTag, "/R7 busy"}, W'(busy), W'(mBusy));
      check({phaseTag, "/R7 done"}, W'(done), W'(mDone));
      check({phaseTag, "/R3 result"}, result,
            (mK == W && mWord == '0 && !mBusy && !mDone) ? result : expectAfter(mWord, mK));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Start a word at a negedge, wait for done, then check length and value
  task automatic convert(input logic [W-1:0] x, input logic [W-1:0] exp, input string tag);
    int busyCycles = 0;
    phaseTag = tag;
    start = 1'b1;
    dataIn = x;
    @(negedge clk);
    start = 1'b0;
    dataIn = ~x;
    while (!done) begin
      if (busy) busyCycles++;
      @(negedge clk);
    end
    check({tag, "/R7 busy length"}, W'(busyCycles), W'(W));
    check({tag, "/R9 value"}, result, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 busy after reset", W'(busy), '0);
    check("R1 done after reset", W'(done), '0);
    check("R1 result after reset", result, '0);

    // R2: loaded word visible the cycle after start
    phaseTag = "R2";
    start = 1'b1; dataIn = 8'h5C;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", W'(busy), 1);
    check("R2 loaded word", result, 8'h5C);
    while (!done) @(negedge clk);
    check("R9 5C", result, 8'hA4);

    convert(8'h0A, 8'hF6, "R9");   // back to back with the previous done
    convert(8'h01, 8'hFF, "R4");   // first bit is the 1
    convert(8'h02, 8'hFE, "R6");   // follows a word that set the state
    convert(8'h00, 8'h00, "R10");
    convert(8'h80, 8'h80, "R10");
    convert(8'hFF, 8'h01, "R5");
    convert(8'h40, 8'hC0, "R4");

    // R8: start with other data mid-word and in the last busy cycle
    phaseTag = "R8";
    start = 1'b1; dataIn = 8'h33;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; dataIn = 8'hE7;
    @(negedge clk);
    start = 1'b0;
    repeat (W - 4) @(negedge clk);
    check("R8 still busy in last shift cycle", W'(busy), 1);
    start = 1'b1; dataIn = 8'h11;   // in the last busy cycle: ignored
    @(negedge clk);
    start = 1'b0;
    check("R8 done after last shift", W'(done), 1);
    check("R8 result unaffected", result, 8'hCD);
    @(negedge clk);
    check("R8 no restart", W'(busy), 0);

    // Varied words
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] v;
      v = W'(i * 37 + 11);
      convert(v, W'(-v), "R9");
    end

    // R1: reset during a word
    phaseTag = "R1";
    start = 1'b1; dataIn = 8'h6B;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 busy after mid-word reset", W'(busy), 0);
    check("R1 result after mid-word reset", result, '0);
    convert(8'h6B, 8'h95, "R6");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule